// File: doc/BRIEF.md
# Exception Entry and Fault Capture Unit

This unit sits next to the fetch and commit stages of a simple in-order core. When the core raises a fault, the unit receives a single-cycle fault pulse. The pulse carries a 4-bit fault code, the current PC, the faulting instruction word, the faulting virtual address, six access-flag bits, and qualifiers: privileged mode, speculative, page-table-entry load and no-fault probe. On the next clock edge the unit redirects fetch to the handler entry point. That entry point is a privileged base register plus a fixed per-code vector offset.

On the same edge the unit updates the exception-address register. It also latches the data-side or instruction-side fault registers, but only when the fault qualifies.

A small register port lets software do three things. It can write the privileged base and the two page-table base registers. It can read those bases back. It can read the captured fault state.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, fetchPc is 0x1 and fetchNextPc is 0x5, and redirect is low. Every register on the access port reads zero.
- R2: Fault codes map to vector offsets as follows:
  - 0 reset: 0x0001
  - 1 instruction access violation: 0x0081
  - 2 interrupt: 0x0101
  - 3 instruction miss: 0x0181
  - 4 instruction page fault: 0x0181
  - 5 single data miss: 0x0201
  - 6 double data miss: 0x0281
  - 7 unaligned: 0x0301
  - 8 data page fault: 0x0381
  - 9 data access violation: 0x0381
  - 10 machine check: 0x0401
  - 11 illegal opcode: 0x0481
  - 12 arithmetic: 0x0501
  - 13 FP disabled: 0x0581
  - 14 privileged call: 0x2001

  One edge after a fault pulse, redirect is high for exactly one cycle, fetchPc equals the privileged base plus the offset, and fetchNextPc equals fetchPc + 4.
- R3: Fault code 15 is ignored. It causes no redirect, fetchPc does not change, and no register changes.
- R4: The exception address (register 3) is loaded with the fault PC when the core is not in privileged mode, or when the code is 0 or 10. Otherwise it keeps its value.
- R5: For codes 12 and 14, the exception address is incremented by 4 after any load in R4. If there was no load, the held value is incremented by 4.
- R6: Codes 5 to 9 are data faults. A data fault that is not speculative, not a page-table-entry load and not a no-fault probe latches three registers:
  - register 4 gets the virtual address;
  - register 5 gets instruction bits [31:26] at [16:11], instruction bits [25:21] at [10:6], and the flags at [5:0];
  - register 6 gets the data page-table base OR (vaddr >> 13) << 3.
- R7: A data fault that is speculative, a page-table-entry load or a no-fault probe leaves registers 4 to 6 unchanged. It still redirects.
- R8: Codes 1, 3 and 4 are instruction faults. A non-speculative instruction fault latches the PC into register 7, and latches the instruction page-table base OR (pc >> 13) << 3 into register 8. A speculative instruction fault leaves both unchanged.
- R9: The register map is:
  - address 0: privileged base, read/write;
  - address 1: data page-table base, read/write;
  - address 2: instruction page-table base, read/write;
  - addresses 3 to 8: read-only.

  A write is visible on the following cycle. Writes to the read-only addresses have no effect, and addresses 9 to 15 read zero.
- R10: If a base-register write coincides with a fault, the fault uses the value the base had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | 1 | Single-cycle fault strobe |
| faultCode | input | 4 | Fault code (see R2) |
| privMode | input | 1 | Core is in privileged mode |
| specFault | input | 1 | Fault belongs to a misspeculated path |
| reqPte | input | 1 | Access was a page-table-entry load |
| reqNoFault | input | 1 | Access was a no-fault probe |
| curPc | input | 64 | PC of the faulting instruction |
| instWord | input | 32 | Faulting instruction word |
| faultVa | input | 64 | Faulting data virtual address |
| accFlags | input | 6 | Access flags for the data status register |
| regAddr | input | 4 | Register-port address |
| regWe | input | 1 | Register-port write enable |
| regWdata | input | 64 | Register-port write data |
| regRdata | output | 64 | Register-port read data (combinational) |
| fetchPc | output | 64 | Redirected fetch PC |
| fetchNextPc | output | 64 | fetchPc + 4 |
| redirect | output | 1 | One-cycle redirect strobe |

## Verification
Some behaviours are checked on every cycle by the assertions:
- the one-cycle shape of the redirect pulse and the +4 relation between the two fetch outputs;
- the stability of the exception address when neither a load nor a skip is called for;
- the stability of the data capture registers when capture is not qualified;
- that data and instruction capture never fire together.

Other behaviours only show in the bench's scenarios, because each depends on an exact value:
- the exact vector offset of every code;
- the packing of the data status word;
- the formatted-address arithmetic;
- the old-value behaviour on a coincident base write;
- the handling of the ignored code 15.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    FC_RESET    = 4'd0,
    FC_IACV     = 4'd1,
    FC_INTR     = 4'd2,
    FC_IMISS    = 4'd3,
    FC_IPAGE    = 4'd4,
    FC_DMISS1   = 4'd5,
    FC_DMISS2   = 4'd6,
    FC_UNALIGN  = 4'd7,
    FC_DPAGE    = 4'd8,
    FC_DACV     = 4'd9,
    FC_MCHK     = 4'd10,
    FC_OPDEC    = 4'd11,
    FC_ARITH    = 4'd12,
    FC_FPDIS    = 4'd13,
    FC_PRIVCALL = 4'd14,
    FC_NONE     = 4'd15
  } faultCode_e;

  localparam int VEC_W = 16;

  // register-port map
  localparam logic [3:0] RA_PRIV_BASE = 4'd0;
  localparam logic [3:0] RA_DPT_BASE  = 4'd1;
  localparam logic [3:0] RA_IPT_BASE  = 4'd2;
  localparam logic [3:0] RA_EXC       = 4'd3;
  localparam logic [3:0] RA_DVA       = 4'd4;
  localparam logic [3:0] RA_DSTAT     = 4'd5;
  localparam logic [3:0] RA_DFORM     = 4'd6;
  localparam logic [3:0] RA_ITAG      = 4'd7;
  localparam logic [3:0] RA_IFORM     = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic             take;
    logic             loadExc;
    logic             skipInst;
    logic             captD;
    logic             captI;
    logic [VEC_W-1:0] vecOff;
  } entryStb_t;

  function automatic logic [VEC_W-1:0] vecOf(input logic [3:0] code);
    case (code)
      FC_RESET:              vecOf = 16'h0001;
      FC_IACV:               vecOf = 16'h0081;
      FC_INTR:               vecOf = 16'h0101;
      FC_IMISS, FC_IPAGE:    vecOf = 16'h0181;
      FC_DMISS1:             vecOf = 16'h0201;
      FC_DMISS2:             vecOf = 16'h0281;
      FC_UNALIGN:            vecOf = 16'h0301;
      FC_DPAGE, FC_DACV:     vecOf = 16'h0381;
      FC_MCHK:               vecOf = 16'h0401;
      FC_OPDEC:              vecOf = 16'h0481;
      FC_ARITH:              vecOf = 16'h0501;
      FC_FPDIS:              vecOf = 16'h0581;
      FC_PRIVCALL:           vecOf = 16'h2001;
      default:               vecOf = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultValid,
  input  logic [3:0] faultCode,
  input  logic       privMode,
  input  logic       specFault,
  input  logic       reqPte,
  input  logic       reqNoFault,
  output entryStb_t  stb
);

  logic isData, isInst, forceRestart, skipCode, take;

  always_comb begin
    isData       = (faultCode >= FC_DMISS1) && (faultCode <= FC_DACV);
    isInst       = (faultCode == FC_IACV) || (faultCode == FC_IMISS) ||
                   (faultCode == FC_IPAGE);
    forceRestart = (faultCode == FC_RESET) || (faultCode == FC_MCHK);
    skipCode     = (faultCode == FC_ARITH) || (faultCode == FC_PRIVCALL);
    take         = faultValid && (faultCode != FC_NONE);
  end

  always_comb begin
    stb.take     = take;
    stb.loadExc  = take && (forceRestart || !privMode);
    stb.skipInst = take && skipCode;
    stb.captD    = take && isData && !specFault && !reqPte && !reqNoFault;
    stb.captI    = take && isInst && !specFault;
    stb.vecOff   = vecOf(faultCode);
  end

  // R6
  capt_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.captD, stb.captI}));

  // R4
  priv_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && privMode && faultCode != FC_RESET && faultCode != FC_MCHK)
      |-> !stb.loadExc);

endmodule

// File: rtl/exc_dpath.sv
module exc_dpath
  import exc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int INST_W     = 32,
  parameter int FLAG_W     = 6,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStb_t         stb,
  input  logic [VA_W-1:0]   pc,
  input  logic [INST_W-1:0] inst,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [FLAG_W-1:0] flags,
  input  logic [3:0]        regAddr,
  input  logic              regWe,
  input  logic [VA_W-1:0]   regWdata,
  output logic [VA_W-1:0]   regRdata,
  output logic [VA_W-1:0]   fetchPc,
  output logic [VA_W-1:0]   fetchNextPc,
  output logic              redirect
);

  localparam int OPC_W  = 6;
  localparam int RA_W   = 5;
  localparam int STAT_W = OPC_W + RA_W + FLAG_W;
  localparam logic [VA_W-1:0] RESET_PC = VA_W'(vecOf(FC_RESET));

  logic [VA_W-1:0]   privBase, dPtBase, iPtBase, excAddr;
  logic [VA_W-1:0]   dVa, dForm, iTag, iForm;
  logic [STAT_W-1:0] dStat;
  logic [VA_W-1:0]   target, excBase, excNext;
  logic              unusedInstBits;

  assign unusedInstBits = ^inst[INST_W-OPC_W-RA_W-1:0];

  always_comb begin
    target  = privBase + VA_W'(stb.vecOff);
    excBase = stb.loadExc ? pc : excAddr;
    excNext = excBase + (stb.skipInst ? VA_W'(4) : VA_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchPc     <= RESET_PC;
      fetchNextPc <= RESET_PC + VA_W'(4);
      redirect    <= 1'b0;
      excAddr     <= '0;
    end else begin
      redirect <= stb.take;
      if (stb.take) begin
        fetchPc     <= target;
        fetchNextPc <= target + VA_W'(4);
      end
      if (stb.loadExc || stb.skipInst) excAddr <= excNext;
    end
  end

  // software-written bases
  always_ff @(posedge clk) begin
    if (!rstN) begin
      privBase <= '0;
      dPtBase  <= '0;
      iPtBase  <= '0;
    end else if (regWe) begin
      if (regAddr == RA_PRIV_BASE) privBase <= regWdata;
      if (regAddr == RA_DPT_BASE)  dPtBase  <= regWdata;
      if (regAddr == RA_IPT_BASE)  iPtBase  <= regWdata;
    end
  end

  // fault capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dVa   <= '0;
      dStat <= '0;
      dForm <= '0;
      iTag  <= '0;
      iForm <= '0;
    end else begin
      if (stb.captD) begin
        dVa   <= vaddr;
        dStat <= {inst[INST_W-1 -: OPC_W], inst[INST_W-OPC_W-1 -: RA_W], flags};
        dForm <= dPtBase | ((vaddr >> PAGE_SHIFT) << 3);
      end
      if (stb.captI) begin
        iTag  <= pc;
        iForm <= iPtBase | ((pc >> PAGE_SHIFT) << 3);
      end
    end
  end

  always_comb begin
    case (regAddr)
      RA_PRIV_BASE: regRdata = privBase;
      RA_DPT_BASE:  regRdata = dPtBase;
      RA_IPT_BASE:  regRdata = iPtBase;
      RA_EXC:       regRdata = excAddr;
      RA_DVA:       regRdata = dVa;
      RA_DSTAT:     regRdata = VA_W'(dStat);
      RA_DFORM:     regRdata = dForm;
      RA_ITAG:      regRdata = iTag;
      RA_IFORM:     regRdata = iForm;
      default:      regRdata = '0;
    endcase
  end

  // R2
  redirect_after_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> (redirect && fetchNextPc == fetchPc + VA_W'(4)));

  // R2
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.take |=> !redirect);

  // R4
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadExc && !stb.skipInst) |=> $stable(excAddr));

  // R7
  dcap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.captD |=> ($stable(dVa) && $stable(dStat) && $stable(dForm)));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int INST_W     = 32,
  parameter int FLAG_W     = 6,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [3:0]        faultCode,
  input  logic              privMode,
  input  logic              specFault,
  input  logic              reqPte,
  input  logic              reqNoFault,
  input  logic [VA_W-1:0]   curPc,
  input  logic [INST_W-1:0] instWord,
  input  logic [VA_W-1:0]   faultVa,
  input  logic [FLAG_W-1:0] accFlags,
  input  logic [3:0]        regAddr,
  input  logic              regWe,
  input  logic [VA_W-1:0]   regWdata,
  output logic [VA_W-1:0]   regRdata,
  output logic [VA_W-1:0]   fetchPc,
  output logic [VA_W-1:0]   fetchNextPc,
  output logic              redirect
);

  entryStb_t stb;

  exc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultValid (faultValid),
    .faultCode  (faultCode),
    .privMode   (privMode),
    .specFault  (specFault),
    .reqPte     (reqPte),
    .reqNoFault (reqNoFault),
    .stb        (stb)
  );

  exc_dpath #(
    .VA_W       (VA_W),
    .INST_W     (INST_W),
    .FLAG_W     (FLAG_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .pc          (curPc),
    .inst        (instWord),
    .vaddr       (faultVa),
    .flags       (accFlags),
    .regAddr     (regAddr),
    .regWe       (regWe),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .fetchPc     (fetchPc),
    .fetchNextPc (fetchNextPc),
    .redirect    (redirect)
  );

endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;

  typedef struct packed {
    logic [3:0]  code;
    logic        priv;
    logic        spec;
    logic        pte;
    logic        nof;
    logic [15:0] vec;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'd5,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0201},
    '{4'd6,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0281},
    '{4'd8,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0381},
    '{4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0381},
    '{4'd7,  1'b1, 1'b0, 1'b0, 1'b1, 16'h0301},
    '{4'd3,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0181},
    '{4'd4,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0181},
    '{4'd1,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0081},
    '{4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0501},
    '{4'd14, 1'b1, 1'b0, 1'b0, 1'b0, 16'h2001},
    '{4'd10, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0401},
    '{4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0001},
    '{4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0101},
    '{4'd11, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0481},
    '{4'd13, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0581},
    '{4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0;
  logic [3:0]  faultCode = '0;
  logic        privMode = 1'b0, specFault = 1'b0, reqPte = 1'b0, reqNoFault = 1'b0;
  logic [63:0] curPc = '0, faultVa = '0, regWdata = '0;
  logic [31:0] instWord = '0;
  logic [5:0]  accFlags = '0;
  logic [3:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [63:0] regRdata, fetchPc, fetchNextPc;
  logic        redirect;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [63:0] mPal = '0, mDPt = '0, mIPt = '0, mExc = '0;
  logic [63:0] mDVa = '0, mDStat = '0, mDForm = '0, mITag = '0, mIForm = '0, mPc = 64'h1;

  always #5 clk = ~clk;

  exc_entry_unit u_dut (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultCode(faultCode),
    .privMode(privMode), .specFault(specFault), .reqPte(reqPte), .reqNoFault(reqNoFault),
    .curPc(curPc), .instWord(instWord), .faultVa(faultVa), .accFlags(accFlags),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .fetchPc(fetchPc), .fetchNextPc(fetchNextPc), .redirect(redirect)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic chkReg(input string req, input logic [3:0] a, input logic [63:0] exp);
    logic [63:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic chkAllRegs(input string req);
    chkReg(req, 4'd0, mPal);
    chkReg(req, 4'd1, mDPt);
    chkReg(req, 4'd2, mIPt);
    chkReg(req, 4'd3, mExc);
    chkReg(req, 4'd4, mDVa);
    chkReg(req, 4'd5, mDStat);
    chkReg(req, 4'd6, mDForm);
    chkReg(req, 4'd7, mITag);
    chkReg(req, 4'd8, mIForm);
  endtask

  // apply one fault and update model from the requirements
  task automatic doFault(input vec_t v, input int i);
    logic force_, skip, isD, isI;
    @(negedge clk);
    faultValid = 1'b1; faultCode = v.code; privMode = v.priv;
    specFault = v.spec; reqPte = v.pte; reqNoFault = v.nof;
    curPc    = 64'h0000_0040_0000_1000 + 64'(i) * 64'h2_4680;
    faultVa  = (64'h0000_0123_4567_8000 ^ (64'(i) << 13)) + 64'(i) * 8;
    instWord = 32'h8000_0000 | (32'(i) << 26) | (32'(i ^ 5) << 21) | 32'h1234;
    accFlags = 6'(i) ^ 6'h2A;
    force_ = (v.code == 4'd0) || (v.code == 4'd10);
    skip   = (v.code == 4'd12) || (v.code == 4'd14);
    isD    = (v.code >= 4'd5) && (v.code <= 4'd9);
    isI    = (v.code == 4'd1) || (v.code == 4'd3) || (v.code == 4'd4);
    if (v.code != 4'd15) begin
      mPc = mPal + 64'(v.vec);
      if (force_ || !v.priv) mExc = curPc;
      if (skip) mExc = mExc + 4;
      if (isD && !v.spec && !v.pte && !v.nof) begin
        mDVa   = faultVa;
        mDStat = 64'({instWord[31:26], instWord[25:21], accFlags});
        mDForm = mDPt | ((faultVa >> 13) << 3);
      end
      if (isI && !v.spec) begin
        mITag  = curPc;
        mIForm = mIPt | ((curPc >> 13) << 3);
      end
    end
    @(negedge clk);
    faultValid = 1'b0;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fetchPc", fetchPc, 64'h1);
    chk("R1 fetchNextPc", fetchNextPc, 64'h5);
    chk("R1 redirect", 64'(redirect), 64'h0);
    chkAllRegs("R1 regs");

    // R9 base writes
    wr(4'd0, 64'h0000_0000_0010_0000); mPal = 64'h0000_0000_0010_0000;
    wr(4'd1, 64'hFFF0_0000_0000_0000); mDPt = 64'hFFF0_0000_0000_0000;
    wr(4'd2, 64'h0FF0_0000_0000_0000); mIPt = 64'h0FF0_0000_0000_0000;
    chkAllRegs("R9 base write");

    // vector table walk: R2..R8
    for (int i = 0; i < NV; i++) begin
      doFault(TBL[i], i);
      if (TBL[i].code == 4'd15) begin
        chk("R3 no redirect", 64'(redirect), 64'h0);
        chk("R3 fetchPc held", fetchPc, mPc);
        chkAllRegs("R3 regs held");
      end else begin
        chk("R2 redirect", 64'(redirect), 64'h1);
        chk("R2 fetchPc", fetchPc, mPc);
        chk("R2 fetchNextPc", fetchNextPc, mPc + 4);
        chkReg("R4/R5 exc addr", 4'd3, mExc);
        chkReg("R6/R7 dva", 4'd4, mDVa);
        chkReg("R6/R7 dstat", 4'd5, mDStat);
        chkReg("R6/R7 dform", 4'd6, mDForm);
        chkReg("R8 itag", 4'd7, mITag);
        chkReg("R8 iform", 4'd8, mIForm);
        @(negedge clk);
        chk("R2 pulse width", 64'(redirect), 64'h0);
      end
    end

    // R5 skip without load: privileged arithmetic trap increments held value
    doFault('{4'd12, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0501}, 20);
    chkReg("R5 held plus 4", 4'd3, mExc);

    // R9 read-only write ignored, unmapped reads zero
    wr(4'd3, 64'hDEAD_BEEF_0000_0000);
    chkReg("R9 ro write ignored", 4'd3, mExc);
    wr(4'd4, 64'h1111_2222_3333_4444);
    chkReg("R9 ro dva ignored", 4'd4, mDVa);
    chkReg("R9 unmapped", 4'd9, 64'h0);
    chkReg("R9 unmapped", 4'd15, 64'h0);

    // R10 coincident base write
    @(negedge clk);
    faultValid = 1'b1; faultCode = 4'd2; privMode = 1'b1;
    specFault = 1'b0; reqPte = 1'b0; reqNoFault = 1'b0;
    regWe = 1'b1; regAddr = 4'd0; regWdata = 64'h0000_0000_0040_0000;
    @(negedge clk);
    faultValid = 1'b0; regWe = 1'b0;
    chk("R10 old base used", fetchPc, mPal + 64'h0101);
    mPal = 64'h0000_0000_0040_0000;
    chkReg("R10 new base stored", 4'd0, mPal);
    doFault('{4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0101}, 21);
    chk("R10 new base next fault", fetchPc, mPal + 64'h0101);

    // R10 data base coincident with data capture
    @(negedge clk);
    faultValid = 1'b1; faultCode = 4'd5; privMode = 1'b0;
    curPc = 64'h7000; faultVa = 64'h0000_0000_00AB_C000;
    regWe = 1'b1; regAddr = 4'd1; regWdata = 64'h0;
    @(negedge clk);
    faultValid = 1'b0; regWe = 1'b0;
    chkReg("R10 old dpt base", 4'd6, mDPt | ((64'h0000_0000_00AB_C000 >> 13) << 3));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule